// File: doc/BRIEF.md
# Dual-Buffer Frame Fetch Sequencer

This block runs once for every frame of a display pipeline and decides how the framebuffer in memory is read out. It manages two frame buffers, each bounded by a top and a bottom byte address. A frame that is accepted may first pull a 256-word palette from the head of the current buffer. It then takes the pixel format from the palette header word and works out where the pixel data begins. It checks that the whole frame fits inside the buffer, and finally emits one start address per display line, one line per clock.

Configuration comes in as level inputs that stay stable while a frame runs. The palette is fetched over a simple request port that returns data with a fixed latency. It is held in an internal block RAM that the downstream pixel converter reads through its own read port. Buffer-complete and bound-error conditions are reported on sticky condition bits and a DMA interrupt pulse. When the frame does not fit, the block pulses a sync-error flag and a request for the panel enable to be cleared.

Top module: `frame_fetch_seq`

## Requirements
- R1: After reset, mem_req, line_valid, frame_end, sync_err, en_clr and dma_irq are 0 and cond is 3'b000.
- R2: A frame_start pulse in the idle state does nothing when enable is 0 or pal_mode is 1: no request, no line, no frame_end. A frame_start that arrives while a frame is in progress is ignored.
- R3: When pal_mode is not 2, an accepted frame issues exactly 256 palette requests, one per cycle. The first request appears in the cycle after the accepting edge, at the current buffer's top address, and each later request is 2 bytes higher. The word on mem_rdata in the cycle after each request is stored as the next palette entry, and entry k can be read on pal_rdata one cycle after pal_raddr = k.
- R4: The format code is bits 14:12 of palette entry 0. Code 1 means 2 bpp, 2 means 4 bpp, 3 means 8 bpp, 4 means 12 bpp and 5 means 16 bpp. Codes 0, 6 and 7 end the frame with frame_end and no line, no cond change and no irq.
- R5: Pixel data begins at the buffer top plus a header offset. The offset is 0x20 bytes at 2 or 4 bpp, 0x200 bytes at 8 bpp and 0 at 12 or 16 bpp.
- R6: Let need = offset + width*height*bpp/8 (rounded down). If need is greater than (bottom - top) + 2 of the current buffer, sync_err and en_clr each pulse for one cycle and frame_end follows, with no line and no cond change.
- R7: A frame that passes the fit check sets cond[i], where i is the current buffer index (0 or 1). The cond bits are sticky until reset. dma_irq pulses when dma_ie[0] is 1.
- R8: When dual is 1, the buffer index toggles after every frame that passes the fit check. When dual is 0, it stays the same.
- R9: After reset the buffer index is invalid. The first accepted frame checks bnd_ok[0] and bnd_ok[1], plus bnd_ok[2] and bnd_ok[3] when dual is 1. If any checked bit is 0, the frame sets cond[2], pulses dma_irq when dma_ie[1] is 1, gives frame_end with no request, and the index stays invalid. Otherwise the index becomes 0.
- R10: Lines are emitted on consecutive cycles. Each line has line_valid = 1, line_num = n and line_addr = base + n*step, where step = width*bpp/8. A frame_end follows the last line.
- R11: With sp_en = 0, lines 0 to height-1 are emitted. With sp_en = 1 and sp_first = 1, lines sp_line to height-1 are emitted. With sp_en = 1 and sp_first = 0, lines 0 to sp_line-1 are emitted. An empty range gives no line.
- R12: With pal_mode 2 no palette request is made, and the format code is the one taken from the most recently loaded entry 0. After reset that code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| enable | input | 1 | Panel enable |
| pal_mode | input | 2 | 1: no fetch, 2: skip palette load, else load palette |
| dual | input | 1 | Ping-pong between the two buffers |
| width_m1 | input | LW | Line width in pixels minus one |
| height_m1 | input | LW | Line count minus one |
| buf0_top | input | AW | Buffer 0 first byte address |
| buf0_bot | input | AW | Buffer 0 end byte address |
| buf1_top | input | AW | Buffer 1 first byte address |
| buf1_bot | input | AW | Buffer 1 end byte address |
| bnd_ok | input | 4 | Validity of buf0_top, buf0_bot, buf1_top, buf1_bot |
| dma_ie | input | 2 | Bit 0: buffer-done irq, bit 1: bound-error irq |
| sp_en | input | 1 | Sub-panel clipping on |
| sp_first | input | 1 | Sub-panel line is the first line (else the line count) |
| sp_line | input | LW | Sub-panel line number |
| mem_req | output | 1 | Palette read request |
| mem_addr | output | AW | Palette read byte address |
| mem_rdata | input | 16 | Read data, valid the cycle after a request |
| pal_raddr | input | 8 | Palette read index |
| pal_rdata | output | 16 | Palette entry, one cycle after pal_raddr |
| line_valid | output | 1 | A line start address is present |
| line_addr | output | AW | Line start byte address |
| line_num | output | LW+1 | Line number |
| frame_end | output | 1 | Frame finished or aborted |
| sync_err | output | 1 | Frame overran its buffer |
| en_clr | output | 1 | Request to clear panel enable |
| dma_irq | output | 1 | DMA interrupt pulse |
| cond | output | 3 | Sticky: buffer 0 done, buffer 1 done, bound error |

## Verification
The first palette request is due in the cycle after the edge that accepts frame_start. The bench records the cycle count at that edge and compares it with the cycle in which it first sees mem_req. Every later request and every line must come on the following consecutive cycle, so each event is logged with its cycle number and checked against the first one. The one-cycle status pulses and frame_end come a fixed number of states later, which depends on the palette length. For that reason the bench waits for frame_end, lets two more cycles pass, and then compares the counted pulses and the sticky cond bits with its own model. Palette contents are read back with the one-cycle read latency: the address is set at one falling edge and the data is sampled at the next.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAL,
    ST_DEC,
    ST_CHK,
    ST_LINES
  } ffs_state_e;
endpackage

// File: rtl/ffs_pal_ram.sv
module ffs_pal_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ffs_fmt_dec.sv
module ffs_fmt_dec (
  input  logic [2:0] code,
  output logic       ok,
  output logic [4:0] bpp,
  output logic [9:0] hdr_off
);
  always_comb begin
    ok      = 1'b1;
    bpp     = 5'd0;
    hdr_off = 10'd0;
    case (code)
      3'd1: begin bpp = 5'd2;  hdr_off = 10'h020; end
      3'd2: begin bpp = 5'd4;  hdr_off = 10'h020; end
      3'd3: begin bpp = 5'd8;  hdr_off = 10'h200; end
      3'd4: bpp = 5'd12;
      3'd5: bpp = 5'd16;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ffs_fit_chk.sv
module ffs_fit_chk #(
  parameter int AW = 24,
  parameter int LW = 10,
  localparam int PW = 2 * (LW + 1) + 5,
  localparam int NW = ((PW > AW) ? PW : AW) + 2
) (
  input  logic [AW-1:0] top,
  input  logic [AW-1:0] bot,
  input  logic [LW:0]   width,
  input  logic [LW:0]   height,
  input  logic [4:0]    bpp,
  input  logic [9:0]    off,
  output logic          fits,
  output logic [AW-1:0] step
);
  logic        [NW-1:0] bits_total;
  logic signed [NW-1:0] need;
  logic signed [NW-1:0] room;

  always_comb begin
    bits_total = NW'(width) * NW'(height) * NW'(bpp);
    need       = $signed(NW'(off) + (bits_total >> 3));
    room       = $signed(NW'(bot)) - $signed(NW'(top)) + $signed(NW'(2));
    fits       = (need <= room);
    step       = AW'((NW'(width) * NW'(bpp)) >> 3);
  end
endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq
  import ffs_pkg::*;
#(
  parameter int AW    = 24,
  parameter int LW    = 10,
  parameter int PAL_N = 256,
  localparam int PIW  = $clog2(PAL_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          enable,
  input  logic [1:0]    pal_mode,
  input  logic          dual,
  input  logic [LW-1:0] width_m1,
  input  logic [LW-1:0] height_m1,
  input  logic [AW-1:0] buf0_top,
  input  logic [AW-1:0] buf0_bot,
  input  logic [AW-1:0] buf1_top,
  input  logic [AW-1:0] buf1_bot,
  input  logic [3:0]    bnd_ok,
  input  logic [1:0]    dma_ie,
  input  logic          sp_en,
  input  logic          sp_first,
  input  logic [LW-1:0] sp_line,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  input  logic [PIW-1:0] pal_raddr,
  output logic [15:0]   pal_rdata,
  output logic          line_valid,
  output logic [AW-1:0] line_addr,
  output logic [LW:0]   line_num,
  output logic          frame_end,
  output logic          sync_err,
  output logic          en_clr,
  output logic          dma_irq,
  output logic [2:0]    cond
);
  ffs_state_e state;
  logic           cur, cur_ok, rd_pend;
  logic [PIW-1:0] rcnt, wcnt;
  logic [2:0]     hdr_code;
  logic [4:0]     bpp_q;
  logic [9:0]     off_q;
  logic [AW-1:0]  base, step_q;
  logic [LW:0]    line, stop;

  logic [AW-1:0] cur_top, cur_bot, step_c;
  logic [LW:0]   width, height, first_l, last_l;
  logic          fmt_ok, fits, bnd_pass;
  logic [4:0]    bpp_c;
  logic [9:0]    off_c;

  assign cur_top  = cur ? buf1_top : buf0_top;
  assign cur_bot  = cur ? buf1_bot : buf0_bot;
  assign width    = {1'b0, width_m1} + 1'b1;
  assign height   = {1'b0, height_m1} + 1'b1;
  assign first_l  = (sp_en && sp_first)  ? {1'b0, sp_line} : '0;
  assign last_l   = (sp_en && !sp_first) ? {1'b0, sp_line} : height;
  assign bnd_pass = bnd_ok[0] && bnd_ok[1] && (!dual || (bnd_ok[2] && bnd_ok[3]));

  ffs_pal_ram #(.DEPTH(PAL_N), .DW(16)) u_pal (
    .clk(clk), .we(rd_pend), .waddr(wcnt), .wdata(mem_rdata),
    .raddr(pal_raddr), .rdata(pal_rdata)
  );

  ffs_fmt_dec u_fmt (.code(hdr_code), .ok(fmt_ok), .bpp(bpp_c), .hdr_off(off_c));

  ffs_fit_chk #(.AW(AW), .LW(LW)) u_fit (
    .top(cur_top), .bot(cur_bot), .width(width), .height(height),
    .bpp(bpp_q), .off(off_q), .fits(fits), .step(step_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur        <= 1'b0;
      cur_ok     <= 1'b0;
      rd_pend    <= 1'b0;
      rcnt       <= '0;
      wcnt       <= '0;
      hdr_code   <= 3'd0;
      bpp_q      <= '0;
      off_q      <= '0;
      base       <= '0;
      step_q     <= '0;
      line       <= '0;
      stop       <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      line_valid <= 1'b0;
      line_addr  <= '0;
      line_num   <= '0;
      frame_end  <= 1'b0;
      sync_err   <= 1'b0;
      en_clr     <= 1'b0;
      dma_irq    <= 1'b0;
      cond       <= 3'b000;
    end else begin
      frame_end  <= 1'b0;
      sync_err   <= 1'b0;
      en_clr     <= 1'b0;
      dma_irq    <= 1'b0;
      line_valid <= 1'b0;
      rd_pend    <= mem_req;
      unique case (state)
        ST_IDLE: begin
          if (frame_start && enable && pal_mode != 2'd1) begin
            if (!cur_ok && !bnd_pass) begin
              cond[2]   <= 1'b1;
              dma_irq   <= dma_ie[1];
              frame_end <= 1'b1;
            end else begin
              cur_ok <= 1'b1;
              if (pal_mode != 2'd2) begin
                state    <= ST_PAL;
                mem_req  <= 1'b1;
                mem_addr <= cur_top;
                rcnt     <= '0;
                wcnt     <= '0;
              end else begin
                state <= ST_DEC;
              end
            end
          end
        end
        ST_PAL: begin
          if (mem_req) begin
            if (rcnt == PIW'(PAL_N - 1)) mem_req <= 1'b0;
            else begin
              rcnt     <= rcnt + 1'b1;
              mem_addr <= mem_addr + AW'(2);
            end
          end
          if (rd_pend) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == '0) hdr_code <= mem_rdata[14:12];
            if (wcnt == PIW'(PAL_N - 1)) state <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (!fmt_ok) begin
            frame_end <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            bpp_q <= bpp_c;
            off_q <= off_c;
            state <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (!fits) begin
            sync_err  <= 1'b1;
            en_clr    <= 1'b1;
            frame_end <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            base      <= cur_top + AW'(off_q);
            step_q    <= step_c;
            cond[cur] <= 1'b1;
            dma_irq   <= dma_ie[0];
            if (dual) cur <= ~cur;
            line      <= first_l;
            stop      <= last_l;
            state     <= ST_LINES;
          end
        end
        ST_LINES: begin
          if (line < stop) begin
            line_valid <= 1'b1;
            line_addr  <= base + step_q * AW'(line);
            line_num   <= line;
            line       <= line + 1'b1;
          end else begin
            frame_end <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: palette requests walk upward by one 16-bit word
  p_req_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> mem_addr == $past(mem_addr) + AW'(2));

  // R10: consecutive lines advance by one line and one stride
  p_line_seq_r10: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(line_valid)) |->
      (line_num == $past(line_num) + 1'b1) && (line_addr == $past(line_addr) + step_q));

  // R6: an overrun frame produces no line
  p_sync_no_line_r6: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> !line_valid);

  // R7: condition bits never drop outside reset
  p_cond_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !$fell(cond[0]) && !$fell(cond[1]) && !$fell(cond[2]));

  // R2: palette fetch and line output never overlap
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && line_valid));
endmodule

// File: tb/frame_fetch_seq_bench.sv
module frame_fetch_seq_bench;
  localparam int AW = 24;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs = 1'b0, en = 1'b1, dual = 1'b0, spe = 1'b0, spf = 1'b0;
  logic [1:0] pm = 2'd0, ie = 2'b11;
  logic [LW-1:0] wm1 = '0, hm1 = '0, spl = '0;
  logic [AW-1:0] b0t = 24'h010000, b0b = 24'h011000, b1t = 24'h040000, b1b = 24'h041000;
  logic [3:0] bnd = 4'hF;
  logic [15:0] hdr_word = 16'h3000;
  logic [15:0] mem_rdata;
  logic [7:0] pal_raddr = '0;
  logic mem_req, line_valid, frame_end, sync_err, en_clr, dma_irq;
  logic [AW-1:0] mem_addr, line_addr;
  logic [LW:0] line_num;
  logic [15:0] pal_rdata;
  logic [2:0] cond;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int req_cnt, fe_cnt, sync_cnt, clr_cnt, irq_cnt, ln_cnt, first_req_cyc;
  logic [AW-1:0] first_req_addr;
  logic [AW-1:0] ln_addr [128];
  int ln_num [128];
  int ln_cyc [128];
  bit tb_cur = 0, tb_ok = 0;
  logic [2:0] tb_cond = 3'b000;
  logic [2:0] tb_code = 3'd0;

  always #10 clk = ~clk;

  frame_fetch_seq #(.AW(AW), .LW(LW)) u_frame_fetch_seq (
    .clk(clk), .rst(rst), .frame_start(fs), .enable(en), .pal_mode(pm), .dual(dual),
    .width_m1(wm1), .height_m1(hm1), .buf0_top(b0t), .buf0_bot(b0b),
    .buf1_top(b1t), .buf1_bot(b1b), .bnd_ok(bnd), .dma_ie(ie),
    .sp_en(spe), .sp_first(spf), .sp_line(spl), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pal_raddr(pal_raddr),
    .pal_rdata(pal_rdata), .line_valid(line_valid), .line_addr(line_addr),
    .line_num(line_num), .frame_end(frame_end), .sync_err(sync_err),
    .en_clr(en_clr), .dma_irq(dma_irq), .cond(cond)
  );

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return (a[11:0] == 12'h000) ? hdr_word : (a[16:1] ^ 16'h5a5a);
  endfunction

  function automatic int f_bpp(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 12;
      3'd5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int f_off(input int b);
    if (b == 2 || b == 4) return 32;
    if (b == 8) return 512;
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rdata <= mem_word(mem_addr);
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) begin
        if (req_cnt == 0) begin
          first_req_cyc  = cyc;
          first_req_addr = mem_addr;
        end
        req_cnt++;
      end
      if (frame_end) fe_cnt++;
      if (sync_err) sync_cnt++;
      if (en_clr) clr_cnt++;
      if (dma_irq) irq_cnt++;
      if (line_valid) begin
        if (ln_cnt < 128) begin
          ln_addr[ln_cnt] = line_addr;
          ln_num[ln_cnt]  = int'(line_num);
          ln_cyc[ln_cnt]  = cyc;
        end
        ln_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_frame(input bit extra);
    bit run, bad;
    int e_req = 0, e_fe = 0, e_sync = 0, e_irq = 0, e_nl = 0;
    int bpp, off, need, size, e_step = 0, first = 0, last, start_cyc, t;
    logic [AW-1:0] e_top = '0, e_bot, e_base = '0;
    run = en && pm != 2'd1;
    if (run) begin
      e_fe = 1;
      bad = !tb_ok && !(bnd[0] && bnd[1] && (!dual || (bnd[2] && bnd[3])));
      if (bad) begin
        tb_cond[2] = 1'b1;
        e_irq = ie[1];
      end else begin
        if (!tb_ok) begin tb_cur = 0; tb_ok = 1; end
        e_top = tb_cur ? b1t : b0t;
        e_bot = tb_cur ? b1b : b0b;
        if (pm != 2'd2) begin e_req = 256; tb_code = hdr_word[14:12]; end
        bpp = f_bpp(tb_code);
        if (bpp != 0) begin
          off  = f_off(bpp);
          need = off + ((int'(wm1) + 1) * (int'(hm1) + 1) * bpp) / 8;
          size = int'(e_bot) - int'(e_top);
          if (need > size + 2) begin
            e_sync = 1;
          end else begin
            tb_cond[tb_cur] = 1'b1;
            e_irq  = ie[0];
            e_base = e_top + AW'(off);
            e_step = ((int'(wm1) + 1) * bpp) / 8;
            first  = (spe && spf) ? int'(spl) : 0;
            last   = (spe && !spf) ? int'(spl) : int'(hm1) + 1;
            e_nl   = (last > first) ? last - first : 0;
            if (dual) tb_cur = ~tb_cur;
          end
        end
      end
    end
    req_cnt = 0; fe_cnt = 0; sync_cnt = 0; clr_cnt = 0; irq_cnt = 0; ln_cnt = 0;
    first_req_cyc = -1;
    @(negedge clk);
    start_cyc = cyc;
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    if (extra) begin
      repeat (4) @(negedge clk);
      fs = 1'b1;
      @(negedge clk);
      fs = 1'b0;
    end
    if (run) begin
      t = 0;
      while (fe_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
      chk(t < 3000, "R10 frame_end timeout", t, 0);
    end else begin
      repeat (30) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(req_cnt == e_req, (pm == 2'd2) ? "R12 request count" : "R3 request count", req_cnt, e_req);
    if (e_req != 0) begin
      chk(first_req_addr == e_top, "R8 first request address", first_req_addr, e_top);
      chk(first_req_cyc == start_cyc + 1, "R3 first request cycle", first_req_cyc, start_cyc + 1);
    end
    chk(fe_cnt == e_fe, "R2 frame_end count", fe_cnt, e_fe);
    chk(sync_cnt == e_sync, "R6 sync_err count", sync_cnt, e_sync);
    chk(clr_cnt == e_sync, "R6 en_clr count", clr_cnt, e_sync);
    chk(irq_cnt == e_irq, "R7 dma_irq count", irq_cnt, e_irq);
    chk(cond == tb_cond, "R7 cond bits", cond, tb_cond);
    chk(ln_cnt == e_nl, (bpp == 0 && run) ? "R4 line count" : "R11 line count", ln_cnt, e_nl);
    for (int i = 0; i < e_nl && i < ln_cnt && i < 128; i++) begin
      chk(ln_num[i] == first + i, "R11 line number", ln_num[i], first + i);
      chk(ln_addr[i] == e_base + AW'(e_step * (first + i)), "R10 R5 line address",
          ln_addr[i], e_base + AW'(e_step * (first + i)));
      chk(ln_cyc[i] == ln_cyc[0] + i, "R10 line cycle", ln_cyc[i], ln_cyc[0] + i);
    end
  endtask

  task automatic pal_check(input int k, input logic [AW-1:0] top);
    @(negedge clk);
    pal_raddr = 8'(k);
    @(negedge clk);
    chk(pal_rdata == mem_word(top + AW'(2 * k)), "R3 palette entry", pal_rdata,
        mem_word(top + AW'(2 * k)));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !line_valid && !frame_end && !sync_err && !en_clr && !dma_irq,
        "R1 outputs after reset", {mem_req, line_valid, frame_end, sync_err, en_clr, dma_irq}, 0);
    chk(cond == 3'b000, "R1 cond after reset", cond, 0);

    // R9 bound failure on first frame, then single mode ignores buffer 1 bounds
    bnd = 4'b1101; ie = 2'b10;
    do_frame(0);
    bnd = 4'b0111; ie = 2'b11;
    do_frame(0);

    // R5 8 bpp with palette, readback R3
    bnd = 4'hF; hdr_word = 16'h3000; wm1 = 10'd15; hm1 = 10'd7;
    do_frame(0);
    pal_check(0, b0t); pal_check(1, b0t); pal_check(255, b0t);

    // R12 skip palette load, reuse code
    pm = 2'd2; do_frame(0);
    // R2 ignored frames
    pm = 2'd1; do_frame(0);
    pm = 2'd0; en = 1'b0; do_frame(0);
    en = 1'b1;
    // R2 second start while busy
    do_frame(1);
    // R8 dual toggling
    dual = 1'b1; hdr_word = 16'h1000; do_frame(0); do_frame(0); do_frame(0);
    dual = 1'b0;
    // R11 sub-panel both forms
    hdr_word = 16'h5000; spe = 1'b1; spf = 1'b1; spl = 10'd3; do_frame(0);
    spf = 1'b0; spl = 10'd5; do_frame(0);
    spf = 1'b1; spl = 10'd20; do_frame(0);
    spe = 1'b0;
    // R6 overrun
    b1b = b1t + 24'h40; dual = 1'b1; do_frame(0); do_frame(0);
    dual = 1'b0; b0b = b0t + 24'h1000;
    // R4 unsupported codes
    hdr_word = 16'h6000; do_frame(0);
    hdr_word = 16'h0000; do_frame(0);

    for (int n = 0; n < 30; n++) begin
      wm1  = LW'($urandom_range(0, 63));
      hm1  = LW'($urandom_range(0, 23));
      b0t  = AW'(32'h010000 + 32'h1000 * $urandom_range(0, 15));
      b1t  = AW'(32'h040000 + 32'h1000 * $urandom_range(0, 15));
      b0b  = b0t + AW'($urandom_range(0, 4608));
      b1b  = b1t + AW'($urandom_range(0, 4608));
      hdr_word = 16'($urandom_range(0, 7) << 12) | 16'h0123;
      pm   = ($urandom_range(0, 9) == 0) ? 2'd1 : 2'($urandom_range(0, 3) == 0 ? 2 : 0);
      en   = ($urandom_range(0, 9) != 0);
      dual = $urandom_range(0, 1) == 1;
      ie   = 2'($urandom_range(0, 3));
      spe  = $urandom_range(0, 2) == 0;
      spf  = $urandom_range(0, 1) == 1;
      spl  = LW'($urandom_range(0, 30));
      do_frame(0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule